// File: doc/BRIEF.md
# Region Sharer Predictor with Miss Completion Control

This block sits beside a core's last-level cache and speeds up load and instruction misses by guessing which other core holds the line. It keeps a direct-mapped table keyed by 1 KB address region. Each entry stores the core that most recently supplied data for that region. When a miss arrives and the region has an entry, the block sends a data request straight to the guessed core. In the same cycle it sends an ordering notification to the home directory. When the region has no entry, only a plain request goes to the directory.

Data and ordering travel separately, so the block also decides when a line may be handed to the L1. Data from the guessed core waits in a holding register until the directory acknowledges the request. A directory refusal discards that held data, and the block then waits for the line to come back through the directory. A refusal from the guessed core makes the block reissue the request to the directory without a guess. Whenever a miss completes, the table entry for the region is rewritten with the core that actually supplied the line. Only one miss is handled at a time.

Top module: `sharer_pred`

## Requirements
- R1: After reset, busy_o, l1_valid_o, peer_req_valid_o and dir_req_valid_o are low, and every table entry is empty, so the first miss is never predicted.
- R2: A miss accepted while its region has no valid entry raises dir_req_valid_o for one cycle, starting the cycle after acceptance. In that cycle dir_req_hint_o=0, peer_req_valid_o=0 and req_addr_o equals the miss address.
- R3: When a miss completes, the table records the supplying core against the miss region. For directory-sourced data that core is dir_src_i. For data from the guessed core it is the guessed core.
- R4: A miss that finds a valid entry raises peer_req_valid_o and dir_req_valid_o together for one cycle, starting the cycle after acceptance. In that cycle dir_req_hint_o=1 and peer_req_core_o carries the recorded core. The region index is address bits [15:10] and the tag is bits [31:16], so any address within the same 1 KB region hits the same entry.
- R5: A miss whose index matches a valid entry but whose tag differs is handled as unpredicted.
- R6: On a predicted miss, l1_valid_o rises one cycle after both the guessed core's data and the directory ACK have arrived, in either order or in the same cycle. l1_data_o then carries the guessed core's data. l1_valid_o stays low until both have arrived.
- R7: A directory NACK on a predicted miss discards any data from the guessed core, including data arriving in the same cycle as the NACK. Later data from the guessed core is ignored. The L1 receives only the line delivered with dir_data_valid_i.
- R8: A NACK from the guessed core causes dir_req_valid_o to be raised the next cycle with dir_req_hint_o=0, peer_req_valid_o=0 and the same address.
- R9: After a misprediction (a NACK from either side), the table entry is overwritten with dir_src_i of the line that completes the miss.
- R10: busy_o is high from the cycle after acceptance until the cycle in which l1_valid_o pulses, and that pulse lasts one cycle. A miss presented while busy_o is high issues no request and does not change the outcome of the miss in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| miss_valid_i | input | 1 | Miss presented this cycle |
| miss_addr_i | input | ADDR_W | Miss address |
| busy_o | output | 1 | A miss is in flight; new misses are ignored |
| peer_req_valid_o | output | 1 | Direct request to the guessed core |
| peer_req_core_o | output | CORE_W | Guessed core |
| dir_req_valid_o | output | 1 | Request or notification to the home directory |
| dir_req_hint_o | output | 1 | 1: notification accompanying a direct request; 0: plain request |
| req_addr_o | output | ADDR_W | Address of the outgoing request |
| peer_data_valid_i | input | 1 | Data from the guessed core |
| peer_data_i | input | DATA_W | Line data from the guessed core |
| peer_nack_i | input | 1 | Guessed core cannot supply the line |
| dir_ack_i | input | 1 | Directory has ordered the predicted request |
| dir_nack_i | input | 1 | Directory rejects the prediction |
| dir_data_valid_i | input | 1 | Line delivered through the directory path |
| dir_data_i | input | DATA_W | Line data through the directory path |
| dir_src_i | input | CORE_W | Core that supplied the directory-path line |
| l1_valid_o | output | 1 | Line handed to the L1 |
| l1_data_o | output | DATA_W | Line data to the L1 |

## Verification
Two situations can fall in the same cycle, and both affect the held peer data. The first is the guessed core's data arriving together with the directory ACK. The bench drives both in one cycle and expects l1_valid_o exactly one cycle later, carrying the peer data. The second is the guessed core's data arriving together with a directory NACK. The bench drives both in one cycle and then supplies stray peer data and a later directory line, and it judges the case by l1_data_o equal to the directory line and by no earlier l1_valid_o pulse.

// File: rtl/pred_pkg.sv
package pred_pkg;
  typedef enum logic [1:0] {S_IDLE, S_PRED, S_DIR} miss_st_e;
endpackage

// File: rtl/pred_table.sv
module pred_table #(
  parameter int RGN_W   = 22,
  parameter int ENTRIES = 64,
  parameter int CORE_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RGN_W-1:0]  lk_region_i,
  output logic              lk_hit_o,
  output logic [CORE_W-1:0] lk_core_o,
  input  logic              wr_en_i,
  input  logic [RGN_W-1:0]  wr_region_i,
  input  logic [CORE_W-1:0] wr_core_i
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = RGN_W - IDX_W;

  logic              vld_q  [ENTRIES];
  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic [CORE_W-1:0] core_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, wr_tag;
  assign lk_idx = lk_region_i[IDX_W-1:0];
  assign lk_tag = lk_region_i[RGN_W-1:IDX_W];
  assign wr_idx = wr_region_i[IDX_W-1:0];
  assign wr_tag = wr_region_i[RGN_W-1:IDX_W];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e]  <= 1'b0;
        tag_q[e]  <= '0;
        core_q[e] <= '0;
      end else if (wr_en_i && wr_idx == IDX_W'(e)) begin
        vld_q[e]  <= 1'b1;
        tag_q[e]  <= wr_tag;
        core_q[e] <= wr_core_i;
      end
    end
  end

  assign lk_hit_o  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_core_o = core_q[lk_idx];
endmodule

// File: rtl/miss_ctrl.sv
module miss_ctrl
  import pred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CORE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              lk_hit_i,
  input  logic [CORE_W-1:0] lk_core_i,
  output logic              busy_o,
  output logic              peer_req_valid_o,
  output logic [CORE_W-1:0] peer_req_core_o,
  output logic              dir_req_valid_o,
  output logic              dir_req_hint_o,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              peer_data_valid_i,
  input  logic [DATA_W-1:0] peer_data_i,
  input  logic              peer_nack_i,
  input  logic              dir_ack_i,
  input  logic              dir_nack_i,
  input  logic              dir_data_valid_i,
  input  logic [DATA_W-1:0] dir_data_i,
  input  logic [CORE_W-1:0] dir_src_i,
  output logic              l1_valid_o,
  output logic [DATA_W-1:0] l1_data_o,
  output logic              wr_en_o,
  output logic [CORE_W-1:0] wr_core_o
);
  miss_st_e          state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CORE_W-1:0] core_q;
  logic              got_data_q, got_ack_q;
  logic [DATA_W-1:0] hold_q;
  logic              pred_done, dir_done;

  always_comb begin
    pred_done = (state_q == S_PRED) && (got_data_q || peer_data_valid_i) &&
                (got_ack_q || dir_ack_i) && !dir_nack_i && !peer_nack_i;
    dir_done  = (state_q == S_DIR) && dir_data_valid_i;
    wr_en_o   = pred_done || dir_done;
    wr_core_o = pred_done ? core_q : dir_src_i;
  end

  assign busy_o          = (state_q != S_IDLE);
  assign req_addr_o      = addr_q;
  assign peer_req_core_o = core_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q          <= S_IDLE;
      addr_q           <= '0;
      core_q           <= '0;
      got_data_q       <= 1'b0;
      got_ack_q        <= 1'b0;
      hold_q           <= '0;
      peer_req_valid_o <= 1'b0;
      dir_req_valid_o  <= 1'b0;
      dir_req_hint_o   <= 1'b0;
      l1_valid_o       <= 1'b0;
      l1_data_o        <= '0;
    end else begin
      peer_req_valid_o <= 1'b0;
      dir_req_valid_o  <= 1'b0;
      l1_valid_o       <= 1'b0;
      unique case (state_q)
        S_IDLE: if (miss_valid_i) begin
          addr_q           <= miss_addr_i;
          core_q           <= lk_core_i;
          peer_req_valid_o <= lk_hit_i;
          dir_req_valid_o  <= 1'b1;
          dir_req_hint_o   <= lk_hit_i;
          got_data_q       <= 1'b0;
          got_ack_q        <= 1'b0;
          state_q          <= lk_hit_i ? S_PRED : S_DIR;
        end
        S_PRED: begin
          if (peer_nack_i) begin
            // retry without a guess
            dir_req_valid_o <= 1'b1;
            dir_req_hint_o  <= 1'b0;
            got_data_q      <= 1'b0;
            state_q         <= S_DIR;
          end else if (dir_nack_i) begin
            got_data_q <= 1'b0;
            state_q    <= S_DIR;
          end else if (pred_done) begin
            l1_valid_o <= 1'b1;
            l1_data_o  <= peer_data_valid_i ? peer_data_i : hold_q;
            state_q    <= S_IDLE;
          end else begin
            if (peer_data_valid_i) begin
              got_data_q <= 1'b1;
              hold_q     <= peer_data_i;
            end
            if (dir_ack_i) got_ack_q <= 1'b1;
          end
        end
        S_DIR: if (dir_data_valid_i) begin
          l1_valid_o <= 1'b1;
          l1_data_o  <= dir_data_i;
          state_q    <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2
  unpred_no_peer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_req_valid_o && !dir_req_hint_o) |-> !peer_req_valid_o);
  // R4
  peer_with_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peer_req_valid_o |-> (dir_req_valid_o && dir_req_hint_o));
  // R6
  hold_until_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PRED && !got_ack_q && !dir_ack_i) |=> !l1_valid_o);
  // R8
  peer_nack_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PRED && peer_nack_i) |=> (dir_req_valid_o && !dir_req_hint_o));
  // R10
  l1_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_valid_o |=> !l1_valid_o);
  // R10
  l1_frees_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_valid_o |-> !busy_o);
endmodule

// File: rtl/sharer_pred.sv
module sharer_pred #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int CORE_W     = 4,
  parameter int ENTRIES    = 64,
  parameter int REGION_LSB = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  output logic              busy_o,
  output logic              peer_req_valid_o,
  output logic [CORE_W-1:0] peer_req_core_o,
  output logic              dir_req_valid_o,
  output logic              dir_req_hint_o,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              peer_data_valid_i,
  input  logic [DATA_W-1:0] peer_data_i,
  input  logic              peer_nack_i,
  input  logic              dir_ack_i,
  input  logic              dir_nack_i,
  input  logic              dir_data_valid_i,
  input  logic [DATA_W-1:0] dir_data_i,
  input  logic [CORE_W-1:0] dir_src_i,
  output logic              l1_valid_o,
  output logic [DATA_W-1:0] l1_data_o
);
  localparam int RGN_W = ADDR_W - REGION_LSB;

  logic              lk_hit, wr_en;
  logic [CORE_W-1:0] lk_core, wr_core;

  pred_table #(.RGN_W(RGN_W), .ENTRIES(ENTRIES), .CORE_W(CORE_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_region_i (miss_addr_i[ADDR_W-1:REGION_LSB]),
    .lk_hit_o    (lk_hit),
    .lk_core_o   (lk_core),
    .wr_en_i     (wr_en),
    .wr_region_i (req_addr_o[ADDR_W-1:REGION_LSB]),
    .wr_core_i   (wr_core)
  );

  miss_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CORE_W(CORE_W)) u_ctrl (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .miss_valid_i      (miss_valid_i),
    .miss_addr_i       (miss_addr_i),
    .lk_hit_i          (lk_hit),
    .lk_core_i         (lk_core),
    .busy_o            (busy_o),
    .peer_req_valid_o  (peer_req_valid_o),
    .peer_req_core_o   (peer_req_core_o),
    .dir_req_valid_o   (dir_req_valid_o),
    .dir_req_hint_o    (dir_req_hint_o),
    .req_addr_o        (req_addr_o),
    .peer_data_valid_i (peer_data_valid_i),
    .peer_data_i       (peer_data_i),
    .peer_nack_i       (peer_nack_i),
    .dir_ack_i         (dir_ack_i),
    .dir_nack_i        (dir_nack_i),
    .dir_data_valid_i  (dir_data_valid_i),
    .dir_data_i        (dir_data_i),
    .dir_src_i         (dir_src_i),
    .l1_valid_o        (l1_valid_o),
    .l1_data_o         (l1_data_o),
    .wr_en_o           (wr_en),
    .wr_core_o         (wr_core)
  );
endmodule

// File: tb/sharer_pred_test.sv
`timescale 1ns/1ps
module sharer_pred_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        miss_valid = 0, peer_dv = 0, peer_nack = 0, dir_ack = 0, dir_nack = 0, dir_dv = 0;
  logic [31:0] miss_addr = 0;
  logic [63:0] peer_data = 0, dir_data = 0;
  logic [3:0]  dir_src = 0;
  logic        busy, peer_req, dir_req, hint, l1_v;
  logic [3:0]  peer_core;
  logic [31:0] req_addr;
  logic [63:0] l1_d;

  sharer_pred uut (
    .clk_i(clk), .rst_ni(rst_n), .miss_valid_i(miss_valid), .miss_addr_i(miss_addr),
    .busy_o(busy), .peer_req_valid_o(peer_req), .peer_req_core_o(peer_core),
    .dir_req_valid_o(dir_req), .dir_req_hint_o(hint), .req_addr_o(req_addr),
    .peer_data_valid_i(peer_dv), .peer_data_i(peer_data), .peer_nack_i(peer_nack),
    .dir_ack_i(dir_ack), .dir_nack_i(dir_nack), .dir_data_valid_i(dir_dv),
    .dir_data_i(dir_data), .dir_src_i(dir_src), .l1_valid_o(l1_v), .l1_data_o(l1_d));

  int checks = 0, errors = 0;
  bit done = 0;
  bit         rv [64];
  logic [15:0] rt [64];
  logic [3:0]  rc [64];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one response cycle: drive after negedge, clear at the next negedge
  task automatic cyc(input bit pdv, input bit pn, input bit da, input bit dn, input bit ddv,
                     input logic [63:0] pd, input logic [63:0] dd, input logic [3:0] src);
    peer_dv = pdv; peer_nack = pn; dir_ack = da; dir_nack = dn; dir_dv = ddv;
    peer_data = pd; dir_data = dd; dir_src = src;
    @(negedge clk);
    peer_dv = 0; peer_nack = 0; dir_ack = 0; dir_nack = 0; dir_dv = 0;
  endtask

  function automatic logic [31:0] mk_addr(input int tg, input int idx, input int off);
    return {15'd0, 1'(tg), 6'(idx), 10'(off)};
  endfunction

  task automatic dir_finish(input logic [31:0] a, input string req);
    logic [3:0]  src = 4'($urandom);
    logic [63:0] dd  = {$urandom, $urandom};
    cyc(0, 0, 0, 0, 1, 0, dd, src);
    chk({req, " l1_valid"}, l1_v, 1);
    chk({req, " l1_data"}, l1_d, dd);
    chk("R10 busy released", busy, 0);
    rv[a[15:10]] = 1; rt[a[15:10]] = a[31:16]; rc[a[15:10]] = src;
  endtask

  task automatic run_miss(input logic [31:0] a, input int sc, input int gap);
    int idx = a[15:10];
    bit hit = rv[idx] && rt[idx] == a[31:16];
    string tg = hit ? "R4" : (rv[idx] ? "R5" : "R2");
    logic [63:0] pd = {$urandom, $urandom};
    miss_valid = 1; miss_addr = a;
    @(negedge clk);
    miss_valid = 0;
    chk({tg, " dir_req"}, dir_req, 1);
    chk({tg, " hint"}, hint, hit);
    chk({tg, " peer_req"}, peer_req, hit);
    chk({tg, " addr"}, req_addr, a);
    chk("R10 busy", busy, 1);
    if (hit) chk("R3 recorded core", peer_core, rc[idx]);
    if (!hit) begin
      for (int g = 0; g < gap; g++) begin
        miss_valid = 1; miss_addr = a ^ 32'h0001_0400;
        @(negedge clk);
        miss_valid = 0;
        chk("R10 ignored miss", dir_req, 0);
        chk("R10 no early l1", l1_v, 0);
      end
      dir_finish(a, "R3");
      return;
    end
    case (sc)
      0, 1: begin
        cyc(sc == 0, 0, sc == 1, 0, 0, pd, 0, 0);
        chk("R6 held", l1_v, 0);
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          chk("R6 held gap", l1_v, 0);
        end
        cyc(sc == 1, 0, sc == 0, 0, 0, pd, 0, 0);
        chk("R6 l1_valid", l1_v, 1);
        chk("R6 l1_data", l1_d, pd);
      end
      2: begin
        cyc(1, 0, 1, 0, 0, pd, 0, 0);
        chk("R6 same cycle l1_valid", l1_v, 1);
        chk("R6 same cycle l1_data", l1_d, pd);
      end
      3: begin
        bit same = $urandom % 2;
        if (!same) begin
          cyc(1, 0, 0, 0, 0, pd, 0, 0);
          chk("R7 held", l1_v, 0);
        end
        cyc(same, 0, 0, 1, 0, pd, 0, 0);
        chk("R7 nack no l1", l1_v, 0);
        cyc(1, 0, 1, 0, 0, ~pd, 0, 0);
        chk("R7 stray peer ignored", l1_v, 0);
        dir_finish(a, "R7");
      end
      default: begin
        cyc(0, 1, 0, 0, 0, 0, 0, 0);
        chk("R8 retry dir_req", dir_req, 1);
        chk("R8 retry hint", hint, 0);
        chk("R8 retry no peer", peer_req, 0);
        chk("R8 retry addr", req_addr, a);
        dir_finish(a, "R9");
      end
    endcase
    if (sc <= 2) rc[idx] = rc[idx];
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) rv[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 l1_valid", l1_v, 0);
    chk("R1 peer_req", peer_req, 0);
    chk("R1 dir_req", dir_req, 0);
    rst_n = 1;
    @(negedge clk);
    run_miss(mk_addr(0, 1, 16), 0, 2);
    for (int s = 0; s < 5; s++) run_miss(mk_addr(0, 1, 8 * (s + 3)), s, 1);
    run_miss(mk_addr(1, 1, 40), 0, 0);
    run_miss(mk_addr(1, 1, 900), 2, 0);
    for (int i = 0; i < 400; i++)
      run_miss(mk_addr($urandom % 2, $urandom % 4, $urandom % 1024), $urandom % 5, $urandom % 4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule